// File: doc/BRIEF.md
# Serial Frame Transmitter

This block sends 16-bit words over a synchronous serial line. A word enters a one-entry holding register through a valid/ready write port. When the transmitter is enabled and a frame sync is seen on a launch edge of the serial clock, the word moves into a shift register. It is then driven onto the data line one bit per launch edge. The launch edge is either the rising or the falling edge of the serial clock, as the polarity control selects. The bit order, most significant or least significant bit first, is chosen at frame start and kept for the whole word.

The serial clock and frame sync are sampled in the system clock domain. The system clock must run at least four times faster than the serial clock. The write port never applies back-pressure: `wr_ready` is always high, and a write into a full holding register replaces the word held there. A data-empty flag tells the producer when the holding register may be refilled. An underrun flag records that a frame began with nothing to send, in which case the previously sent word is sent again.

Clearing the enable does not cut a word short. The word in flight runs to its last bit, and only then is the output enable dropped so that the pad goes to high impedance. While disabled, the block still accepts writes but starts no frames.

Top module: `sft_tx`

## Requirements
- R1: After reset, `txd`=0, `txd_oe`=0, `data_empty`=1, `underrun`=0 and `wr_ready`=1.
- R2: A frame starts only on a launch edge with `tx_en`=1 and `fsync`=1, and only while the line is idle or on the launch edge that ends the last bit of the previous word. A launch edge with `fsync`=0, or with `tx_en`=0, starts nothing and leaves `txd` at 0.
- R3: With `lsb_first`=0 at frame start, bit 15 is sent first and bit 0 last. With `lsb_first`=1, bit 0 is sent first. A change of `lsb_first` during a word does not affect that word.
- R4: With `fall_launch`=0 the launch edge is the rising edge of `sclk`; with `fall_launch`=1 it is the falling edge. One bit is sent per launch edge. `txd` shows the new bit after the first `clk` rising edge at which the new `sclk` level is present, and it does not change on the other `sclk` edge.
- R5: `data_empty` is set when a frame start takes the holding word. It is cleared by any write (`wr_valid`=1). A write in the same cycle as a frame start is applied after the take.
- R6: A frame start with `data_empty`=1 sets `underrun` and resends the most recently taken word (0 if none has been taken). `underrun` stays set until a write clears it. Setting wins over clearing in the same cycle.
- R7: After the last bit of a word, the next launch edge without a new frame start drives `txd` to 0. `txd` is 0 whenever `txd_oe` is 0.
- R8: `txd_oe` is 1 while `tx_en`=1 or a word is in flight. If `tx_en` is cleared in the middle of a word, the remaining bits are still sent correctly and `txd_oe` falls at the launch edge after the last bit. While disabled, writes are accepted and clear `data_empty`, and no frame starts.
- R9: Frames can run back to back: a frame sync on the launch edge after bit 16 starts the next word with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| fall_launch | input | 1 | 0: rising `sclk` edge launches bits; 1: falling edge |
| lsb_first | input | 1 | 0: MSB first; 1: LSB first (sampled at frame start) |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| fsync | input | 1 | Frame sync, sampled on launch edges |
| wr_valid | input | 1 | Write request for the holding register |
| wr_ready | output | 1 | Always 1: write accepted in the same cycle |
| wr_data | input | 16 | Word to load into the holding register |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Output enable for the data pad (0 = high impedance) |
| data_empty | output | 1 | Holding register may be refilled |
| underrun | output | 1 | A frame started with the holding register empty |

## Verification
The same timing applies to a data bit and to the flags. A bit on `txd`, together with the `data_empty` and `underrun` changes caused by a frame start, appears after the first `clk` rising edge that sees the new `sclk` level. A write changes the flags one `clk` edge after the cycle in which `wr_valid` is high. `txd_oe` follows `tx_en` in the same cycle and falls one edge after the closing launch edge. The bench changes `sclk`, `fsync` and the write port only on falling `clk` edges and samples one full `clk` period later, on the next falling edge, so each result is read in the cycle it is due. After each non-launch `sclk` edge it also checks that `txd` has kept its value.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int unsigned SFT_WORD_W = 16;

  typedef struct packed {
    logic enable;
    logic fall_launch;
    logic lsb_first;
  } sft_ctl_t;
endpackage

// File: rtl/sft_edge_sel.sv
module sft_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic fall_launch,
  output logic launch
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  // launch edge: rising when fall_launch=0, falling otherwise
  always_comb begin
    if (fall_launch) launch = sclk_q & ~sclk;
    else             launch = ~sclk_q & sclk;
  end
endmodule

// File: rtl/sft_hold_reg.sv
module sft_hold_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic [WORD_W-1:0] word_o,
  output logic              empty_o,
  output logic              urun_o
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] last_q;
  logic              empty_q;
  logic              urun_q;

  // an empty holding register hands out the previous word again
  assign word_o  = empty_q ? last_q : hold_q;
  assign empty_o = empty_q;
  assign urun_o  = urun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      last_q  <= '0;
      empty_q <= 1'b1;
      urun_q  <= 1'b0;
    end else begin
      if (take && !empty_q) last_q <= hold_q;
      if (wr_fire) hold_q <= wr_data;
      if (wr_fire)   empty_q <= 1'b0;
      else if (take) empty_q <= 1'b1;
      if (take && empty_q) urun_q <= 1'b1;
      else if (wr_fire)    urun_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              start_req,
  input  logic              lsb_first,
  input  logic [WORD_W-1:0] word_i,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] rev_w;
  logic [WORD_W-1:0] src_w;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              txd_q;
  logic              word_done;

  // order is fixed at load by mirroring the word; shifting is always MSB-first
  for (genvar g = 0; g < WORD_W; g++) begin : g_rev
    assign rev_w[g] = word_i[WORD_W-1-g];
  end

  assign src_w     = lsb_first ? rev_w : word_i;
  assign word_done = busy_q && (left_q == '0);
  assign take      = launch && start_req && (!busy_q || word_done);
  assign busy      = busy_q;
  assign txd       = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b0;
    end else if (take) begin
      txd_q  <= src_w[WORD_W-1];
      sh_q   <= src_w << 1;
      left_q <= LAST_CNT;
      busy_q <= 1'b1;
    end else if (launch && busy_q) begin
      if (word_done) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b0;
      end else begin
        txd_q  <= sh_q[WORD_W-1];
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sft_tx.sv
module sft_tx
  import sft_pkg::*;
#(
  parameter int unsigned WORD_W = SFT_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              fall_launch,
  input  logic              lsb_first,
  input  logic              sclk,
  input  logic              fsync,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              txd,
  output logic              txd_oe,
  output logic              data_empty,
  output logic              underrun
);
  sft_ctl_t          ctl;
  logic              launch;
  logic              take;
  logic              busy;
  logic [WORD_W-1:0] next_word;

  assign ctl      = '{enable: tx_en, fall_launch: fall_launch, lsb_first: lsb_first};
  assign wr_ready = 1'b1;
  assign txd_oe   = ctl.enable | busy;

  sft_edge_sel u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .fall_launch (ctl.fall_launch),
    .launch      (launch)
  );

  sft_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_valid & wr_ready),
    .wr_data (wr_data),
    .take    (take),
    .word_o  (next_word),
    .empty_o (data_empty),
    .urun_o  (underrun)
  );

  sft_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .start_req (ctl.enable & fsync),
    .lsb_first (ctl.lsb_first),
    .word_i    (next_word),
    .take      (take),
    .busy      (busy),
    .txd       (txd)
  );
endmodule

// File: rtl/sft_tx_chk.sv
module sft_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic fall_launch,
  input logic sclk,
  input logic wr_valid,
  input logic wr_ready,
  input logic txd,
  input logic txd_oe,
  input logic data_empty,
  input logic underrun
);
  logic sclk_seen;
  logic edge_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_seen <= 1'b0;
    else        sclk_seen <= sclk;
  end

  assign edge_now = fall_launch ? (sclk_seen & ~sclk) : (~sclk_seen & sclk);

  AST_OE_WHILE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> txd_oe); // R8

  AST_LINE_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> !txd); // R7

  AST_TXD_MOVES_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_now |=> $stable(txd)); // R4

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !data_empty); // R5

  AST_URUN_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(data_empty)); // R6

  AST_URUN_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !edge_now) |=> !underrun); // R6
endmodule

bind sft_tx sft_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .fall_launch (fall_launch),
  .sclk        (sclk),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .txd         (txd),
  .txd_oe      (txd_oe),
  .data_empty  (data_empty),
  .underrun    (underrun)
);

// File: tb/sft_tx_test.sv
`timescale 1ns/1ps
module sft_tx_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, fall_launch = 1'b0, lsb_first = 1'b0;
  logic sclk = 1'b0, fsync = 1'b0, wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, txd, txd_oe, data_empty, underrun;

  int checks = 0;
  int fails = 0;

  // bench model of the holding side
  logic [W-1:0] m_hold = '0, m_last = '0;
  logic m_empty = 1'b1, m_urun = 1'b0;

  always #5 clk = ~clk;

  sft_tx uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fall_launch(fall_launch),
    .lsb_first(lsb_first), .sclk(sclk), .fsync(fsync), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .txd(txd), .txd_oe(txd_oe),
    .data_empty(data_empty), .underrun(underrun)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [W-1:0] w);
    wr_valid = 1'b1; wr_data = w;
    step();
    wr_valid = 1'b0;
    m_hold = w; m_empty = 1'b0; m_urun = 1'b0;
  endtask

  task automatic launch_edge(input logic fs);
    sclk = ~fall_launch; fsync = fs;
    step();
    fsync = 1'b0;
  endtask

  task automatic trail_edge();
    sclk = fall_launch;
    step();
  endtask

  task automatic set_pol(input logic p);
    fall_launch = p; sclk = p;
    step();
  endtask

  function automatic logic exp_bit(input logic [W-1:0] w, input logic lsb, input int i);
    return lsb ? w[i] : w[W-1-i];
  endfunction

  // one word; drop_at disables after that bit, mid_write loads a word during the frame
  task automatic run_frame(input string req, input int drop_at, input bit flip_lsb,
                           input bit mid_write, input logic [W-1:0] mid_word);
    logic [W-1:0] w;
    logic lsb;
    lsb = lsb_first;
    if (m_empty) begin w = m_last; m_urun = 1'b1; end
    else begin w = m_hold; m_last = m_hold; m_empty = 1'b1; end
    for (int i = 0; i < W; i++) begin
      logic held;
      launch_edge(i == 0);
      chk(req, $sformatf("bit %0d", i), {31'd0, txd}, {31'd0, exp_bit(w, lsb, i)});
      if (i == 0) begin
        chk("R5", "data_empty after start", {31'd0, data_empty}, {31'd0, m_empty});
        chk("R6", "underrun after start", {31'd0, underrun}, {31'd0, m_urun});
        if (flip_lsb) lsb_first = ~lsb_first;
      end
      held = txd;
      trail_edge();
      chk("R4", "txd held on trailing edge", {31'd0, txd}, {31'd0, held});
      if (mid_write && i == 2) do_write(mid_word);
      if (i == drop_at) begin
        tx_en = 1'b0;
        step();
        chk("R8", "oe kept mid-word", {31'd0, txd_oe}, 32'd1);
      end
    end
  endtask

  task automatic end_frame(input logic fs);
    launch_edge(fs);
    chk("R7", "line low after word", {31'd0, txd}, 32'd0);
    trail_edge();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1", "txd", {31'd0, txd}, 32'd0);
    chk("R1", "txd_oe", {31'd0, txd_oe}, 32'd0);
    chk("R1", "data_empty", {31'd0, data_empty}, 32'd1);
    chk("R1", "underrun", {31'd0, underrun}, 32'd0);
    chk("R1", "wr_ready", {31'd0, wr_ready}, 32'd1);

    // writes while disabled
    do_write(16'hA5C3);
    chk("R8", "write while disabled", {31'd0, data_empty}, 32'd0);
    launch_edge(1'b1);
    chk("R8", "no start while disabled", {31'd0, txd_oe}, 32'd0);
    chk("R2", "line idle when disabled", {31'd0, txd}, 32'd0);
    chk("R8", "flag kept while disabled", {31'd0, data_empty}, 32'd0);
    trail_edge();

    // enabled but no sync
    tx_en = 1'b1;
    launch_edge(1'b0);
    chk("R2", "no start without sync", {31'd0, txd}, 32'd0);
    chk("R2", "word kept without sync", {31'd0, data_empty}, 32'd0);
    trail_edge();

    // MSB first, order change mid-word ignored, write during frame, back-to-back LSB frame
    run_frame("R3", -1, 1'b1, 1'b1, 16'h1234);
    run_frame("R9", -1, 1'b0, 1'b0, '0);
    end_frame(1'b0);
    chk("R8", "oe stays while enabled", {31'd0, txd_oe}, 32'd1);

    // underrun resends last word
    lsb_first = 1'b0;
    run_frame("R6", -1, 1'b0, 1'b0, '0);
    end_frame(1'b0);
    do_write(16'h6E2B);
    chk("R6", "write clears underrun", {31'd0, underrun}, 32'd0);

    // falling-edge launch
    set_pol(1'b1);
    run_frame("R4", -1, 1'b0, 1'b0, '0);
    end_frame(1'b0);

    // disable mid-word
    do_write(16'h3C5A);
    run_frame("R8", 4, 1'b0, 1'b0, '0);
    chk("R8", "oe until word end", {31'd0, txd_oe}, 32'd1);
    launch_edge(1'b1);
    chk("R8", "oe drops after word", {31'd0, txd_oe}, 32'd0);
    chk("R7", "line low after stop", {31'd0, txd}, 32'd0);
    chk("R8", "flags kept on disable", {30'd0, data_empty, underrun}, {30'd0, m_empty, m_urun});
    trail_edge();

    // random frames
    void'($urandom(32'h5EED));
    tx_en = 1'b1;
    for (int n = 0; n < 40; n++) begin
      set_pol(1'($urandom_range(0, 1)));
      lsb_first = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 9) < 7) do_write(16'($urandom));
      run_frame(lsb_first ? "R3" : "R2", -1, 1'b0, 1'b0, '0);
      end_frame(1'b0);
    end
    finish_up();
  end
endmodule